// File: doc/BRIEF.md
# Quadrature NCO Mixer

This block moves a real intermediate-frequency sample stream down to complex baseband. Each clock it takes one signed 12-bit sample. It multiplies that sample by the cosine and by the negated sine of a numerically controlled oscillator, and it gives back an in-phase (I) and a quadrature (Q) sample, each 16 bits. The I and Q results go to a decimating filter chain, which lies outside this block.

The oscillator uses a 32-bit phase accumulator. A tuning word sets the step that is added each clock. A separate offset word, written independently, is added to the accumulator to form the lookup phase. A sync pulse clears the accumulator, so the sample taken in the sync cycle uses exactly the offset word. This lets several channels start from a known, common phase. A small register write port loads both words. The sine and cosine values come from a table built inside the block at elaboration time. The table is addressed by the top 10 phase bits, and a parameter selects whether it stores a quarter wave or a full wave.

Top module: `nco_quad_mixer`

## Requirements
- R1: After reset, out_valid, out_i and out_q are 0, and the tuning and offset words are both 0.
- R2: out_valid in cycle t+3 equals in_valid in cycle t, counting from the cycle in which the input is presented. The I/Q results for that sample appear in the same cycle t+3.
- R3: Let p be bits 31:22 of the lookup phase, and let θ = (p + 0.5)·2π/1024. Then out_i = floor(x·C/2048 + 0.5), where x is the sample and C is 32767·cos θ rounded to an integer, give or take one table LSB.
- R4: out_q = floor(x·(−S)/2048 + 0.5), where S is 32767·sin θ rounded, using the same phase as R3.
- R5: After every clock edge outside reset, the accumulator has advanced by the tuning word modulo 2^32, whether or not in_valid is high.
- R6: The lookup phase is accumulator + offset, modulo 2^32. When sync is high in a cycle, that cycle's sample uses a phase equal to the offset word, and the accumulator then holds the tuning word.
- R7: A write with cfg_we=1 loads cfg_wdata into the tuning word when cfg_sel=0 and into the offset word when cfg_sel=1. The new word is used from the next cycle on. The accumulator step on the write edge still uses the old tuning word.
- R8: Phase bits 21:0 have no effect on the outputs.
- R9: Full-scale samples (−2048 and +2047) do not overflow, and neither output ever takes the value −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 tuning word, 1 offset word |
| cfg_wdata | input | 32 | Write data |
| sync | input | 1 | Clears the phase accumulator |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 12 | Signed input sample |
| out_valid | output | 1 | Output qualifier |
| out_i | output | 16 | Signed in-phase result |
| out_q | output | 16 | Signed quadrature result |

## Verification
A sample presented in cycle t is captured on three edges in turn: phase/address, table, then rounded product. Its I, Q and valid results are therefore due in cycle t+3. The bench records each sample's expected value in a small ring buffer, indexed by the cycle in which the sample was driven. It reads the outputs on the falling edge two ticks after each driven tick, which is exactly the cycle in which that entry is due. Register writes and sync act on the edge that ends their cycle. The bench's phase model therefore computes each sample's phase before that edge, and it updates the accumulator with the old tuning word before it applies any write. This keeps R5 to R7 exact to the cycle.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

   typedef enum logic {
      SEL_TUNE   = 1'b0,
      SEL_OFFSET = 1'b1
   } cfg_target_e;

   // pi scaled by 2^30
   localparam longint PI_Q30 = 64'd3373259426;

   // Sine of the centre of quarter-wave bin idx, out of 2^qbits bins,
   // evaluated by a Taylor series in Q30 and scaled to amp.
   function automatic longint quarter_sine(input int idx, input int qbits, input longint amp);
      longint x;
      longint term;
      longint acc;
      x    = (longint'(2 * idx + 1) * PI_Q30) >>> (qbits + 2);
      term = x;
      acc  = x;
      for (int n = 1; n < 8; n++) begin
         term = (term * x) >>> 30;
         term = (term * x) >>> 30;
         term = -term / longint'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      return (acc * amp + (longint'(1) <<< 29)) >>> 30;
   endfunction

   // Full-wave value for address a of an aw-bit table, built from quarter bins.
   function automatic longint full_sine(input int a, input int aw, input longint amp);
      int qbits;
      int quad;
      int idx;
      int mask;
      qbits = aw - 2;
      mask  = (1 << qbits) - 1;
      quad  = (a >> qbits) & 3;
      idx   = a & mask;
      if (quad[0])
         idx = mask - idx;
      if (quad[1])
         return -quarter_sine(idx, qbits, amp);
      return quarter_sine(idx, qbits, amp);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
   import nco_mix_pkg::*;
#(
   parameter int PH_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic            cfg_sel,
   input  logic [PH_W-1:0] cfg_wdata,
   input  logic            sync,
   output logic [PH_W-1:0] phase,
   output logic [PH_W-1:0] acc_o,
   output logic [PH_W-1:0] tune_o,
   output logic [PH_W-1:0] offset_o
);

   logic [PH_W-1:0] acc_q;
   logic [PH_W-1:0] tune_q;
   logic [PH_W-1:0] offset_q;
   logic [PH_W-1:0] acc_base;
   cfg_target_e     target;

   assign target   = cfg_target_e'(cfg_sel);
   assign acc_base = sync ? '0 : acc_q;
   assign phase    = acc_base + offset_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         tune_q   <= '0;
         offset_q <= '0;
      end else begin
         acc_q <= acc_base + tune_q;
         if (cfg_we) begin
            if (target == SEL_OFFSET)
               offset_q <= cfg_wdata;
            else
               tune_q <= cfg_wdata;
         end
      end
   end

   assign acc_o    = acc_q;
   assign tune_o   = tune_q;
   assign offset_o = offset_q;

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
   import nco_mix_pkg::*;
#(
   parameter int AW           = 10,
   parameter int AMP_W        = 16,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           addr,
   output logic signed [AMP_W-1:0] cos_o,
   output logic signed [AMP_W-1:0] sin_o
);

   localparam int     QW    = AW - 2;
   localparam longint AMP   = (longint'(1) <<< (AMP_W - 1)) - 1;

   logic signed [AMP_W-1:0] sin_d;
   logic signed [AMP_W-1:0] cos_d;

   generate
      if (QUARTER_WAVE) begin : g_quarter
         localparam int DEPTH = 1 << QW;
         logic signed [AMP_W-1:0] rom [DEPTH];
         logic [QW-1:0]           idx;
         logic [QW-1:0]           mir;
         logic [1:0]              quad;
         logic signed [AMP_W-1:0] fwd;
         logic signed [AMP_W-1:0] rev;

         for (genvar g = 0; g < DEPTH; g++) begin : g_rom
            assign rom[g] = AMP_W'(quarter_sine(g, QW, AMP));
         end

         assign quad = addr[AW-1 -: 2];
         assign idx  = addr[QW-1:0];
         assign mir  = ~idx;
         assign fwd  = rom[idx];
         assign rev  = rom[mir];

         always_comb begin
            unique case (quad)
               2'd0: begin sin_d = fwd;  cos_d = rev;  end
               2'd1: begin sin_d = rev;  cos_d = -fwd; end
               2'd2: begin sin_d = -fwd; cos_d = -rev; end
               default: begin sin_d = -rev; cos_d = fwd; end
            endcase
         end
      end else begin : g_full
         localparam int DEPTH = 1 << AW;
         logic signed [AMP_W-1:0] rom [DEPTH];
         logic [AW-1:0]           cos_addr;

         for (genvar g = 0; g < DEPTH; g++) begin : g_rom
            assign rom[g] = AMP_W'(full_sine(g, AW, AMP));
         end

         assign cos_addr = addr + AW'(1 << QW);
         assign sin_d    = rom[addr];
         assign cos_d    = rom[cos_addr];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cos_o <= '0;
         sin_o <= '0;
      end else begin
         cos_o <= cos_d;
         sin_o <= sin_d;
      end
   end

endmodule

// File: rtl/nco_round_mult.sv
module nco_round_mult #(
   parameter int IN_W  = 12,
   parameter int AMP_W = 16,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [IN_W-1:0]  sample,
   input  logic signed [AMP_W-1:0] coef,
   output logic signed [OUT_W-1:0] result
);

   localparam int PW  = IN_W + AMP_W;
   localparam int SHR = PW - 1 - OUT_W;

   logic signed [PW-1:0]    prod;
   logic signed [OUT_W-1:0] res_d;

   assign prod = PW'(sample) * PW'(coef);

   generate
      if (SHR > 0) begin : g_round
         logic signed [PW-1:0] biased;
         assign biased = prod + (PW'(1) <<< (SHR - 1));
         assign res_d  = biased[SHR +: OUT_W];
      end else begin : g_plain
         assign res_d = prod[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         result <= '0;
      else
         result <= res_d;
   end

endmodule

// File: rtl/nco_quad_mixer.sv
module nco_quad_mixer #(
   parameter int IN_W         = 12,
   parameter int PH_W         = 32,
   parameter int LUT_AW       = 10,
   parameter int AMP_W        = 16,
   parameter int OUT_W        = 16,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic                    cfg_sel,
   input  logic [PH_W-1:0]         cfg_wdata,
   input  logic                    sync,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_sample,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);

   localparam int LANES = 2;

   generate
      if (LUT_AW < 3 || LUT_AW > PH_W) begin : g_bad_aw
         $error("nco_quad_mixer: LUT_AW must lie in 3..PH_W");
      end
      if (AMP_W < 4 || AMP_W > 24) begin : g_bad_amp
         $error("nco_quad_mixer: AMP_W must lie in 4..24");
      end
      if (OUT_W > IN_W + AMP_W - 1) begin : g_bad_out
         $error("nco_quad_mixer: OUT_W wider than the product");
      end
   endgenerate

   logic [PH_W-1:0] phase_w;
   logic [PH_W-1:0] acc_w;
   logic [PH_W-1:0] tune_w;
   logic [PH_W-1:0] offset_w;

   nco_phase_acc #(.PH_W(PH_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .sync     (sync),
      .phase    (phase_w),
      .acc_o    (acc_w),
      .tune_o   (tune_w),
      .offset_o (offset_w)
   );

   // stage 1: table address and sample
   logic [LUT_AW-1:0]      s1_addr;
   logic signed [IN_W-1:0] s1_x;
   logic                   s1_v;
   // stage 2: table values and sample
   logic signed [IN_W-1:0] s2_x;
   logic                   s2_v;
   logic                   s3_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_addr <= '0;
         s1_x    <= '0;
         s1_v    <= 1'b0;
         s2_x    <= '0;
         s2_v    <= 1'b0;
         s3_v    <= 1'b0;
      end else begin
         s1_addr <= phase_w[PH_W-1 -: LUT_AW];
         s1_x    <= in_sample;
         s1_v    <= in_valid;
         s2_x    <= s1_x;
         s2_v    <= s1_v;
         s3_v    <= s2_v;
      end
   end

   logic signed [AMP_W-1:0] lut_cos;
   logic signed [AMP_W-1:0] lut_sin;

   nco_sincos_lut #(
      .AW          (LUT_AW),
      .AMP_W       (AMP_W),
      .QUARTER_WAVE(QUARTER_WAVE)
   ) u_lut (
      .clk  (clk),
      .rst_n(rst_n),
      .addr (s1_addr),
      .cos_o(lut_cos),
      .sin_o(lut_sin)
   );

   logic signed [AMP_W-1:0] lane_coef [LANES];
   logic signed [OUT_W-1:0] lane_out  [LANES];

   assign lane_coef[0] = lut_cos;
   assign lane_coef[1] = -lut_sin;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      nco_round_mult #(
         .IN_W (IN_W),
         .AMP_W(AMP_W),
         .OUT_W(OUT_W)
      ) u_mult (
         .clk   (clk),
         .rst_n (rst_n),
         .sample(s2_x),
         .coef  (lane_coef[l]),
         .result(lane_out[l])
      );
   end

   assign out_valid = s3_v;
   assign out_i     = lane_out[0];
   assign out_q     = lane_out[1];

endmodule

// File: rtl/nco_quad_mixer_chk.sv
module nco_quad_mixer_chk #(
   parameter int PH_W  = 32,
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_we,
   input logic                    cfg_sel,
   input logic [PH_W-1:0]         cfg_wdata,
   input logic                    sync,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_i,
   input logic signed [OUT_W-1:0] out_q,
   input logic [PH_W-1:0]         acc_w,
   input logic [PH_W-1:0]         tune_w,
   input logic [PH_W-1:0]         offset_w
);

   localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= '0;
      else if (since_rst != 2'd3)
         since_rst <= since_rst + 2'd1;
   end

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd3) |-> !out_valid);

   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   assert_acc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sync |=> (acc_w == $past(acc_w + tune_w)));

   assert_sync_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> (acc_w == $past(tune_w)));

   assert_tune_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> (tune_w == $past(cfg_wdata)));

   assert_offset_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel) |=> (offset_w == $past(cfg_wdata)));

   assert_offset_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(offset_w));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_i != MOST_NEG && out_q != MOST_NEG));

endmodule

bind nco_quad_mixer nco_quad_mixer_chk #(
   .PH_W (PH_W),
   .OUT_W(OUT_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_sel  (cfg_sel),
   .cfg_wdata(cfg_wdata),
   .sync     (sync),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .out_i    (out_i),
   .out_q    (out_q),
   .acc_w    (acc_w),
   .tune_w   (tune_w),
   .offset_w (offset_w)
);

// File: tb/test_nco_quad_mixer.sv
module test_nco_quad_mixer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        sync = 1'b0;
   logic        in_valid = 1'b0;
   logic signed [11:0] in_sample = '0;
   logic        out_valid;
   logic signed [15:0] out_i;
   logic signed [15:0] out_q;

   always #5 clk = ~clk;

   nco_quad_mixer i_nco_quad_mixer (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .sync     (sync),
      .in_valid (in_valid),
      .in_sample(in_sample),
      .out_valid(out_valid),
      .out_i    (out_i),
      .out_q    (out_q)
   );

   int vec_cnt = 0;
   int bad_cnt = 0;
   int tick_n  = 0;

   // bench model of the oscillator registers
   logic [31:0] m_acc  = '0;
   logic [31:0] m_tune = '0;
   logic [31:0] m_off  = '0;

   logic  sl_chk [8];
   logic  sl_v   [8];
   int    sl_i   [8];
   int    sl_q   [8];
   string sl_tag [8];

   initial for (int k = 0; k < 8; k++) sl_chk[k] = 1'b0;

   task automatic check_val(input string tag, input string what, input int act, input int exp, input int tol);
      vec_cnt++;
      if (act - exp > tol || exp - act > tol) begin
         bad_cnt++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic expect_iq(input int x, input logic [31:0] ph, output int ei, output int eq);
      int  p;
      real th;
      int  c;
      int  s;
      p  = int'(ph[31:22]);
      th = (real'(p) + 0.5) * 2.0 * 3.14159265358979 / 1024.0;
      c  = int'($floor(32767.0 * $cos(th) + 0.5));
      s  = int'($floor(32767.0 * $sin(th) + 0.5));
      ei = int'($floor(real'(x * c) / 2048.0 + 0.5));
      eq = int'($floor(real'(-x * s) / 2048.0 + 0.5));
   endtask

   // One clock: drive, advance model, then check the entry due now.
   task automatic tick(input logic v, input int x, input logic sy, input logic we,
                       input logic sel, input logic [31:0] wd, input logic chk, input string tag);
      logic [31:0] ph;
      int ei;
      int eq;
      int slot;
      ph = (sy ? 32'd0 : m_acc) + m_off;
      expect_iq(x, ph, ei, eq);
      slot = tick_n % 8;
      sl_chk[slot] = chk;
      sl_v[slot]   = v;
      sl_i[slot]   = ei;
      sl_q[slot]   = eq;
      sl_tag[slot] = tag;
      in_valid  = v;
      in_sample = x[11:0];
      sync      = sy;
      cfg_we    = we;
      cfg_sel   = sel;
      cfg_wdata = wd;
      @(posedge clk);
      m_acc = sy ? m_tune : m_acc + m_tune;
      if (we) begin
         if (sel) m_off = wd;
         else     m_tune = wd;
      end
      @(negedge clk);
      tick_n++;
      if (tick_n >= 3) begin
         slot = (tick_n - 3) % 8;
         if (sl_chk[slot]) begin
            check_val(sl_tag[slot], "out_valid", int'(out_valid), int'(sl_v[slot]), 0);
            if (sl_v[slot]) begin
               check_val(sl_tag[slot], "out_i", int'(out_i), sl_i[slot], 2);
               check_val(sl_tag[slot], "out_q", int'(out_q), sl_q[slot], 2);
            end
         end
      end
   endtask

   task automatic write_reg(input logic sel, input logic [31:0] wd);
      tick(1'b0, 0, 1'b0, 1'b1, sel, wd, 1'b0, "");
   endtask

   task automatic drain(input string tag);
      repeat (3) tick(1'b0, 0, 1'b0, 1'b0, 1'b0, '0, 1'b1, tag);
   endtask

   task automatic t_reset_R1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_val("R1", "out_valid", int'(out_valid), 0, 0);
      check_val("R1", "out_i", int'(out_i), 0, 0);
      check_val("R1", "out_q", int'(out_q), 0, 0);
      // default words are zero: phase stays at bin 0
      tick(1'b1, 1000, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R1");
      tick(1'b1, -700, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R1");
      drain("R1");
   endtask

   task automatic t_latency_R2;
      tick(1'b1, 500, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R2");
      repeat (4) tick(1'b0, 0, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R2");
      tick(1'b1, -321, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R2");
      tick(1'b1, 321, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R2");
      drain("R2");
   endtask

   task automatic t_quadrants_R3_R4;
      for (int q = 0; q < 4; q++) begin
         write_reg(1'b1, (32'(q) << 30) | 32'h0A00_0000);
         tick(1'b1, 1500, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R3/R4");
         tick(1'b1, -2048, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R9");
         tick(1'b1, 2047, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R9");
      end
      write_reg(1'b1, 32'h0000_0000);
      tick(1'b1, -2048, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R9");
      drain("R3");
   endtask

   task automatic t_low_bits_R8;
      write_reg(1'b1, 32'h003F_FFFF);
      tick(1'b1, 2047, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R8");
      write_reg(1'b1, 32'h0040_0000);
      tick(1'b1, 2047, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R8");
      write_reg(1'b1, 32'h7FFF_FFFF);
      tick(1'b1, -1999, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R8");
      drain("R8");
   endtask

   task automatic t_sweep_R5;
      write_reg(1'b1, 32'h0000_0000);
      write_reg(1'b0, 32'h0123_4567);
      for (int k = 0; k < 40; k++)
         tick(k[0], ((k * 173) % 4096) - 2048, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R5");
      write_reg(1'b0, 32'hC000_0001);
      for (int k = 0; k < 12; k++)
         tick(1'b1, 1800 - k * 300, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R5");
      drain("R5");
   endtask

   task automatic t_sync_R6;
      write_reg(1'b1, 32'h4000_0000);
      write_reg(1'b0, 32'h0100_0000);
      for (int k = 0; k < 6; k++)
         tick(1'b1, 1200, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R6");
      tick(1'b1, 1200, 1'b1, 1'b0, 1'b0, '0, 1'b1, "R6");
      for (int k = 0; k < 5; k++)
         tick(1'b1, -1200, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R6");
      drain("R6");
   endtask

   task automatic t_write_R7;
      write_reg(1'b0, 32'h0200_0000);
      for (int k = 0; k < 3; k++)
         tick(1'b1, 900, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R7");
      // tuning write in the same cycle as a live sample
      tick(1'b1, 900, 1'b0, 1'b1, 1'b0, 32'h1000_0000, 1'b1, "R7");
      for (int k = 0; k < 4; k++)
         tick(1'b1, 900, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R7");
      // offset write while streaming
      tick(1'b1, -900, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 1'b1, "R7");
      for (int k = 0; k < 4; k++)
         tick(1'b1, -900, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R7");
      drain("R7");
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   endtask

   initial begin
      t_reset_R1();
      t_latency_R2();
      t_quadrants_R3_R4();
      t_low_bits_R8();
      t_sweep_R5();
      t_sync_R6();
      t_write_R7();
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      bad_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule